// File: doc/BRIEF.md
# DMA Transfer Counter Engine

This block keeps the running byte count and memory address for a tape-record DMA transfer. It also raises the transfer errors. Software presets the count register with the two's complement of the number of bytes to move. Software also loads an 18-bit address. Its two top bits act as an extension above a 16-bit word address. Each completed memory access moves the count one step up toward zero and the address one word forward. The carry runs into the extension bits.

The engine is told the operation mode (read, write or space) and is then started. The tape side pulses a per-character request. The engine answers with a memory request that it holds until the bus logic reports the access done. It watches the bus grant and the slave reply to detect a late grant or a missing memory. On a read, a record longer than the count stops the memory side but lets the record run to its end. In space mode the counter counts records, and the engine asks for the next command to be re-issued while records remain.

Top module: `dma_xfer_engine`

## Requirements
- R1: After reset the count is 0 with `last_byte` high, and the address, byte select, `xfer_req`, `busy`, `rearm_go` and all three error flags are 0.
- R2: `cnt_load` writes `cnt_value` into the count. Each completed access (`mem_done` while `xfer_req` is high) adds 1 to it. `last_byte` is high exactly when the count is 0.
- R3: Each completed access adds 2 to the 18-bit `cur_addr`. A carry out of bit 15 increments the 2-bit extension (bits 17:16), and the extension wraps from 3 to 0.
- R4: `cur_addr` bit 0 always reads 0. `byte_sel` holds `addr_value` bit 0 from the last `addr_load`, and accesses never change it.
- R5: While busy, in read or write mode, a `char_req` seen with a nonzero count and no request open raises `xfer_req` on the next cycle. `xfer_req` stays high until the cycle after `mem_done`.
- R6: In write mode (`op_mode` 2'b01, and also the spare code 2'b11), a `char_req` seen with a zero count raises no request and sets no error.
- R7: In read mode (`op_mode` 2'b00), a `char_req` seen with a zero count sets `err_rle`. After that, no request is made, and the count and address stay unchanged, until `rec_end` drops `busy`.
- R8: A `char_req` that arrives while `xfer_req` is high and no `bus_grant` has been seen since it rose sets `err_bgl`. It drops `xfer_req` and ends the operation.
- R9: If `master_sync` stays high without `slave_reply` for TIMEOUT_CYC consecutive sampled cycles while busy, `err_nxm` sets, `xfer_req` drops and the operation ends. `cur_addr` keeps the failing location.
- R10: In space mode (`op_mode` 2'b10), each `rec_end` adds 1 to the count. If the new count is nonzero, `rearm_go` pulses for one cycle and the engine stays busy. If the new count is zero, `busy` drops.
- R11: `op_start` sets `busy`, clears all three error flags and latches `op_mode`. In read or write mode, `rec_end` ends the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_mode | input | 2 | 00 read, 01 write, 10 space, 11 acts as write |
| op_start | input | 1 | Begin an operation |
| cnt_load | input | 1 | Load the count |
| cnt_value | input | 16 | Two's-complement preset |
| addr_load | input | 1 | Load the address |
| addr_value | input | 18 | Address preset, bit 0 is byte select |
| char_req | input | 1 | Tape character request |
| rec_end | input | 1 | End-of-record character seen |
| bus_grant | input | 1 | Bus grant for the open request |
| master_sync | input | 1 | Master sync asserted by the bus side |
| slave_reply | input | 1 | Slave reply from memory |
| mem_done | input | 1 | Memory access completed |
| xfer_req | output | 1 | Memory access request |
| cur_addr | output | 18 | Current address, bit 0 reads 0 |
| byte_sel | output | 1 | Byte within the word |
| cnt_out | output | 16 | Current count |
| last_byte | output | 1 | Count is zero |
| busy | output | 1 | Operation in progress |
| err_rle | output | 1 | Record-length error |
| err_bgl | output | 1 | Bus grant late |
| err_nxm | output | 1 | Non-existent memory |
| rearm_go | output | 1 | Re-issue command pulse in space mode |

## Verification
A wrong count or address would show on `cnt_out` or `cur_addr` one cycle after the access that caused it. A lost carry into the extension bits shows only when an access crosses a 64 KiB boundary, so that crossing is driven on purpose. A wrong request or freeze state would show as `xfer_req` rising when it should not. It would also show as the count moving after a record-length error. The reference model compares every port on every cycle, so any such divergence is caught in the first cycle it reaches a port. A faulty sync-timeout counter shows up only at the end of a full timeout window, one cycle early or late on `err_nxm`.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_SPACE = 2'b10
  } dmx_op_e;
endpackage

// File: rtl/dmx_rec_counter.sv
module dmx_rec_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  output logic [W-1:0] count,
  output logic         at_zero
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)      cnt_d = load_val;
    else if (step) cnt_d = cnt_q + {{(W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count   = cnt_q;
  assign at_zero = (cnt_q == '0);
endmodule

// File: rtl/dmx_addr_gen.sv
module dmx_addr_gen #(
  parameter int LO_W  = 16,
  parameter int EXT_W = 2,
  localparam int FULL_W = LO_W + EXT_W,
  localparam int WORD_W = FULL_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [FULL_W-1:0] load_val,
  input  logic              step,
  output logic [FULL_W-1:0] word_addr,
  output logic              byte_sel
);
  logic [LO_W-1:0]   lo_q, lo_d;
  logic [EXT_W-1:0]  ext_q, ext_d;
  logic [WORD_W-1:0] word_cur, word_nxt;

  assign word_cur = {ext_q, lo_q[LO_W-1:1]};
  assign word_nxt = word_cur + {{(WORD_W-1){1'b0}}, 1'b1};

  always_comb begin
    lo_d  = lo_q;
    ext_d = ext_q;
    if (load) begin
      {ext_d, lo_d} = load_val;
    end else if (step) begin
      {ext_d, lo_d[LO_W-1:1]} = word_nxt;
      lo_d[0] = lo_q[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      ext_q <= '0;
    end else begin
      lo_q  <= lo_d;
      ext_q <= ext_d;
    end
  end

  assign word_addr = {ext_q, lo_q[LO_W-1:1], 1'b0};
  assign byte_sel  = lo_q[0];
endmodule

// File: rtl/dmx_sync_watch.sv
module dmx_sync_watch #(
  parameter int TMO = 1250,
  localparam int TW = $clog2(TMO + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic sync,
  input  logic reply,
  output logic expired
);
  logic [TW-1:0] tmr_q, tmr_d;
  logic          run, hit;

  assign run = arm && sync && !reply;
  assign hit = run && (tmr_q == TW'(TMO - 1));

  always_comb begin
    tmr_d = '0;
    if (run && !hit) tmr_d = tmr_q + {{(TW-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_q <= '0;
    else        tmr_q <= tmr_d;
  end

  assign expired = hit;
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
  import dmx_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int ADDR_W      = 16,
  parameter int EXT_W       = 2,
  parameter int TIMEOUT_CYC = 1250,
  localparam int FULL_W = ADDR_W + EXT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        op_mode,
  input  logic              op_start,
  input  logic              cnt_load,
  input  logic [CNT_W-1:0]  cnt_value,
  input  logic              addr_load,
  input  logic [FULL_W-1:0] addr_value,
  input  logic              char_req,
  input  logic              rec_end,
  input  logic              bus_grant,
  input  logic              master_sync,
  input  logic              slave_reply,
  input  logic              mem_done,
  output logic              xfer_req,
  output logic [FULL_W-1:0] cur_addr,
  output logic              byte_sel,
  output logic [CNT_W-1:0]  cnt_out,
  output logic              last_byte,
  output logic              busy,
  output logic              err_rle,
  output logic              err_bgl,
  output logic              err_nxm,
  output logic              rearm_go
);
  dmx_op_e    mode_q, mode_d;
  logic       act_q, act_d, pend_q, pend_d, gr_q, gr_d, frz_q, frz_d;
  logic       rle_q, rle_d, bgl_q, bgl_d, nxm_q, nxm_d, rearm_q, rearm_d;
  logic       cnt_step, addr_step, expired, cnt_zero;
  logic [CNT_W-1:0] cnt_val;

  dmx_rec_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_value),
    .step(cnt_step), .count(cnt_val), .at_zero(cnt_zero)
  );

  dmx_addr_gen #(.LO_W(ADDR_W), .EXT_W(EXT_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(addr_load), .load_val(addr_value),
    .step(addr_step), .word_addr(cur_addr), .byte_sel(byte_sel)
  );

  dmx_sync_watch #(.TMO(TIMEOUT_CYC)) u_watch (
    .clk(clk), .rst_n(rst_n), .arm(act_q), .sync(master_sync),
    .reply(slave_reply), .expired(expired)
  );

  always_comb begin
    mode_d = mode_q; act_d = act_q; pend_d = pend_q; gr_d = gr_q;
    frz_d = frz_q; rle_d = rle_q; bgl_d = bgl_q; nxm_d = nxm_q;
    rearm_d = 1'b0; cnt_step = 1'b0; addr_step = 1'b0;
    if (op_start) begin
      act_d = 1'b1; pend_d = 1'b0; gr_d = 1'b0; frz_d = 1'b0;
      rle_d = 1'b0; bgl_d = 1'b0; nxm_d = 1'b0;
      mode_d = (op_mode == 2'b11) ? OP_WRITE : dmx_op_e'(op_mode);
    end else if (act_q) begin
      if (expired) begin
        nxm_d = 1'b1; act_d = 1'b0; pend_d = 1'b0; gr_d = 1'b0;
      end else begin
        if (pend_q && bus_grant) gr_d = 1'b1;
        if (pend_q && mem_done) begin
          pend_d = 1'b0; gr_d = 1'b0; cnt_step = 1'b1; addr_step = 1'b1;
        end
        if (char_req && (mode_q != OP_SPACE) && !frz_q) begin
          if (pend_q && !gr_q) begin
            bgl_d = 1'b1; act_d = 1'b0; pend_d = 1'b0; gr_d = 1'b0;
          end else if (!pend_q) begin
            if (cnt_zero) begin
              if (mode_q == OP_READ) begin
                rle_d = 1'b1; frz_d = 1'b1;
              end
            end else begin
              pend_d = 1'b1; gr_d = 1'b0;
            end
          end
        end
        if (rec_end) begin
          if (mode_q == OP_SPACE) begin
            cnt_step = 1'b1;
            if (cnt_val != '1) rearm_d = 1'b1;
            else               act_d = 1'b0;
          end else begin
            act_d = 1'b0; pend_d = 1'b0; gr_d = 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= OP_READ; act_q <= 1'b0; pend_q <= 1'b0; gr_q <= 1'b0;
      frz_q <= 1'b0; rle_q <= 1'b0; bgl_q <= 1'b0; nxm_q <= 1'b0;
      rearm_q <= 1'b0;
    end else begin
      mode_q <= mode_d; act_q <= act_d; pend_q <= pend_d; gr_q <= gr_d;
      frz_q <= frz_d; rle_q <= rle_d; bgl_q <= bgl_d; nxm_q <= nxm_d;
      rearm_q <= rearm_d;
    end
  end

  assign xfer_req  = pend_q;
  assign cnt_out   = cnt_val;
  assign last_byte = cnt_zero;
  assign busy      = act_q;
  assign err_rle   = rle_q;
  assign err_bgl   = bgl_q;
  assign err_nxm   = nxm_q;
  assign rearm_go  = rearm_q;
endmodule

// File: rtl/dma_xfer_engine_chk.sv
module dma_xfer_engine_chk #(
  parameter int CNT_W  = 16,
  parameter int FULL_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cnt_load,
  input logic              addr_load,
  input logic              xfer_req,
  input logic              busy,
  input logic [FULL_W-1:0] cur_addr,
  input logic              byte_sel,
  input logic [CNT_W-1:0]  cnt_out,
  input logic              err_rle,
  input logic              err_bgl,
  input logic              err_nxm,
  input logic              rearm_go
);
  p_req_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> busy);

  p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cnt_load) && (cnt_out != $past(cnt_out)))
      |-> (cnt_out == $past(cnt_out) + CNT_W'(1)));

  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(addr_load) && (cur_addr != $past(cur_addr)))
      |-> (cur_addr == $past(cur_addr) + FULL_W'(2)));

  p_bsel_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(addr_load) |-> $stable(byte_sel));

  p_rle_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_rle && $past(err_rle) && !$past(cnt_load)) |-> $stable(cnt_out));

  p_bgl_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_bgl) |-> (!xfer_req && !busy));

  p_nxm_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(err_nxm) && !$past(addr_load)) |-> ($stable(cur_addr) && !xfer_req));

  p_rearm_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rearm_go |-> busy);
endmodule

bind dma_xfer_engine dma_xfer_engine_chk #(.CNT_W(CNT_W), .FULL_W(FULL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_load(cnt_load), .addr_load(addr_load),
  .xfer_req(xfer_req), .busy(busy), .cur_addr(cur_addr), .byte_sel(byte_sel),
  .cnt_out(cnt_out), .err_rle(err_rle), .err_bgl(err_bgl), .err_nxm(err_nxm),
  .rearm_go(rearm_go)
);

// File: tb/dma_xfer_engine_tb.sv
module dma_xfer_engine_tb;
  localparam int TMO = 1250;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] op_mode = 2'b00;
  logic op_start = 0, cnt_load = 0, addr_load = 0, char_req = 0, rec_end = 0;
  logic bus_grant = 0, master_sync = 0, slave_reply = 0, mem_done = 0;
  logic [15:0] cnt_value = '0;
  logic [17:0] addr_value = '0;
  logic xfer_req, byte_sel, last_byte, busy, err_rle, err_bgl, err_nxm, rearm_go;
  logic [17:0] cur_addr;
  logic [15:0] cnt_out;

  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  dma_xfer_engine #(.TIMEOUT_CYC(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_mode(op_mode), .op_start(op_start),
    .cnt_load(cnt_load), .cnt_value(cnt_value), .addr_load(addr_load),
    .addr_value(addr_value), .char_req(char_req), .rec_end(rec_end),
    .bus_grant(bus_grant), .master_sync(master_sync), .slave_reply(slave_reply),
    .mem_done(mem_done), .xfer_req(xfer_req), .cur_addr(cur_addr),
    .byte_sel(byte_sel), .cnt_out(cnt_out), .last_byte(last_byte), .busy(busy),
    .err_rle(err_rle), .err_bgl(err_bgl), .err_nxm(err_nxm), .rearm_go(rearm_go)
  );

  // behavioural reference model
  int m_cnt, m_word, m_mode, m_tmr;
  bit m_bsel, m_act, m_pend, m_gr, m_frz, m_rle, m_bgl, m_nxm, m_rearm;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_word = 0; m_bsel = 0; m_mode = 0; m_tmr = 0;
      m_act = 0; m_pend = 0; m_gr = 0; m_frz = 0;
      m_rle = 0; m_bgl = 0; m_nxm = 0; m_rearm = 0;
    end else begin
      automatic bit step = 0;
      automatic bit run = m_act && master_sync && !slave_reply;
      automatic bit tmo = run && (m_tmr == TMO - 1);
      automatic bit was_pend = m_pend, was_gr = m_gr;
      automatic int old_cnt = m_cnt;
      m_tmr = (run && !tmo) ? m_tmr + 1 : 0;
      m_rearm = 0;
      if (op_start) begin
        m_act = 1; m_pend = 0; m_gr = 0; m_frz = 0;
        m_rle = 0; m_bgl = 0; m_nxm = 0;
        m_mode = (op_mode == 2'b11) ? 1 : int'(op_mode);
      end else if (m_act) begin
        if (tmo) begin
          m_nxm = 1; m_act = 0; m_pend = 0; m_gr = 0;
        end else begin
          if (was_pend && bus_grant) m_gr = 1;
          if (was_pend && mem_done) begin m_pend = 0; m_gr = 0; step = 1; end
          if (char_req && m_mode != 2 && !m_frz) begin
            if (was_pend && !was_gr) begin
              m_bgl = 1; m_act = 0; m_pend = 0; m_gr = 0;
            end else if (!was_pend) begin
              if (old_cnt == 0) begin
                if (m_mode == 0) begin m_rle = 1; m_frz = 1; end
              end else begin
                m_pend = 1; m_gr = 0;
              end
            end
          end
          if (rec_end) begin
            if (m_mode == 2) begin
              step = 1;
              if (old_cnt != 16'hFFFF) m_rearm = 1; else m_act = 0;
            end else begin
              m_act = 0; m_pend = 0; m_gr = 0;
            end
          end
        end
      end
      if (cnt_load) m_cnt = int'(cnt_value);
      else if (step) m_cnt = (m_cnt + 1) % 65536;
      if (addr_load) begin m_word = int'(addr_value) / 2; m_bsel = addr_value[0]; end
      else if (step && !rec_end) m_word = (m_word + 1) % 131072;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // compare every port with the model on every falling edge
  always @(negedge clk) if (rst_n) begin
    chk(cnt_out == 16'(m_cnt), "R2", "cnt_out", cnt_out, m_cnt);
    chk(last_byte == (m_cnt == 0), "R2", "last_byte", last_byte, m_cnt == 0);
    chk(cur_addr == 18'(m_word * 2), "R3", "cur_addr", cur_addr, m_word * 2);
    chk(byte_sel == m_bsel, "R4", "byte_sel", byte_sel, m_bsel);
    chk(xfer_req == m_pend, "R5", "xfer_req", xfer_req, m_pend);
    chk(err_rle == m_rle, "R7", "err_rle", err_rle, m_rle);
    chk(err_bgl == m_bgl, "R8", "err_bgl", err_bgl, m_bgl);
    chk(err_nxm == m_nxm, "R9", "err_nxm", err_nxm, m_nxm);
    chk(rearm_go == m_rearm, "R10", "rearm_go", rearm_go, m_rearm);
    chk(busy == m_act, "R11", "busy", busy, m_act);
  end

  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk); #2; end
  endtask

  task automatic setup(input logic [1:0] md, input logic [15:0] c, input logic [17:0] a);
    op_mode = md; cnt_value = c; addr_value = a;
    cnt_load = 1; addr_load = 1; cyc();
    cnt_load = 0; addr_load = 0; op_start = 1; cyc();
    op_start = 0; cyc();
  endtask

  task automatic one_access();
    char_req = 1; cyc(); char_req = 0; cyc();
    bus_grant = 1; cyc(); bus_grant = 0; cyc();
    mem_done = 1; cyc(); mem_done = 0; cyc();
  endtask

  initial begin
    #100000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1;
    cyc();
    // R1 reset state
    chk(cnt_out == 0 && last_byte && cur_addr == 0 && !byte_sel, "R1", "count/addr", cnt_out, 0);
    chk(!xfer_req && !busy && !err_rle && !err_bgl && !err_nxm && !rearm_go, "R1", "flags",
        {xfer_req, busy, err_rle, err_bgl, err_nxm, rearm_go}, 0);

    // write three bytes, odd byte select
    setup(2'b01, 16'hFFFD, 18'h01001);
    for (int k = 0; k < 3; k++) one_access();
    chk(cnt_out == 16'h0000 && last_byte, "R2", "count after 3", cnt_out, 0);
    chk(cur_addr == 18'h01006, "R3", "addr after 3", cur_addr, 18'h01006);
    chk(byte_sel == 1'b1 && cur_addr[0] == 1'b0, "R4", "byte select", byte_sel, 1);
    // R6 write at zero count: no request, no error
    char_req = 1; cyc(); char_req = 0;
    chk(!xfer_req && !err_rle, "R6", "write at zero", {xfer_req, err_rle}, 0);
    rec_end = 1; cyc(); rec_end = 0; cyc();
    chk(!busy, "R11", "rec_end ends write", busy, 0);

    // spare mode code behaves as write
    setup(2'b11, 16'h0000, 18'h0);
    char_req = 1; cyc(); char_req = 0; cyc();
    chk(!xfer_req && !err_rle, "R6", "spare code as write", {xfer_req, err_rle}, 0);
    rec_end = 1; cyc(); rec_end = 0; cyc();

    // carry into the extension bits
    setup(2'b00, 16'hFFFE, 18'h1FFFE);
    one_access();
    chk(cur_addr == 18'h20000, "R3", "carry into ext", cur_addr, 18'h20000);
    one_access();
    chk(cur_addr == 18'h20002, "R3", "after carry", cur_addr, 18'h20002);
    rec_end = 1; cyc(); rec_end = 0; cyc();
    setup(2'b00, 16'hFFFF, 18'h3FFFE);
    one_access();
    chk(cur_addr == 18'h00000, "R3", "extension wrap", cur_addr, 0);

    // R7 long record on read
    char_req = 1; cyc(); char_req = 0; cyc();
    chk(err_rle && !xfer_req, "R7", "rle set", err_rle, 1);
    char_req = 1; cyc(); char_req = 0; mem_done = 1; cyc(); mem_done = 0; cyc();
    chk(!xfer_req && cnt_out == 0 && cur_addr == 0 && busy, "R7", "frozen",
        {xfer_req, busy}, 2'b01);
    rec_end = 1; cyc(); rec_end = 0; cyc();
    chk(!busy, "R7", "ends at rec_end", busy, 0);
    // R11 start clears errors
    op_start = 1; cyc(); op_start = 0;
    chk(!err_rle && busy, "R11", "start clears", err_rle, 0);
    rec_end = 1; cyc(); rec_end = 0; cyc();

    // R8 bus grant late
    setup(2'b00, 16'hFFFB, 18'h00100);
    char_req = 1; cyc(); char_req = 0; cyc(2);
    chk(xfer_req, "R5", "request raised", xfer_req, 1);
    char_req = 1; cyc(); char_req = 0;
    chk(err_bgl && !xfer_req && !busy, "R8", "grant late", {err_bgl, xfer_req, busy}, 3'b100);
    char_req = 1; cyc(); char_req = 0; cyc();
    chk(!xfer_req && cnt_out == 16'hFFFB, "R8", "no request after bgl", xfer_req, 0);

    // R9 reply in time, then timeout
    setup(2'b00, 16'hFFF0, 18'h00200);
    char_req = 1; cyc(); char_req = 0; bus_grant = 1; cyc(); bus_grant = 0;
    master_sync = 1; cyc(100); slave_reply = 1; cyc(); master_sync = 0; slave_reply = 0;
    mem_done = 1; cyc(); mem_done = 0; cyc();
    chk(!err_nxm && cur_addr == 18'h00202, "R9", "reply in time", err_nxm, 0);
    char_req = 1; cyc(); char_req = 0; bus_grant = 1; cyc(); bus_grant = 0;
    master_sync = 1; cyc(TMO - 1);
    chk(!err_nxm, "R9", "one cycle before timeout", err_nxm, 0);
    cyc();
    chk(err_nxm && !xfer_req && !busy && cur_addr == 18'h00202, "R9", "timeout",
        {err_nxm, xfer_req, busy}, 3'b100);
    master_sync = 0; cyc();

    // R10 space mode
    setup(2'b10, 16'hFFFE, 18'h0);
    rec_end = 1; cyc(); rec_end = 0;
    chk(rearm_go && cnt_out == 16'hFFFF && busy, "R10", "first record", rearm_go, 1);
    cyc();
    chk(!rearm_go, "R10", "rearm one cycle", rearm_go, 0);
    rec_end = 1; cyc(); rec_end = 0;
    chk(!rearm_go && cnt_out == 0 && !busy, "R10", "last record", {rearm_go, busy}, 0);
    cyc(3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule